// File: doc/BRIEF.md
# Three-Source External Interrupt Controller

This block watches three external request pins and turns their activity into interrupt requests for a processor core. Every pin is brought into the clock domain by a two-stage synchronizer and then compared against its previous synchronized value. A per-source sense code chooses what counts as activity: a low level, any change, a falling edge or a rising edge. Sources 0 and 1 have a two-bit sense code. Source 2 has a one-bit code that picks one edge direction.

In an edge mode, detected activity sets a sticky pending flag. In level mode, the source requests for as long as its synchronized pin is low, and no flag is set. Pending sources are filtered by per-source mask bits and by a global enable. The highest-priority survivor is presented as a request plus a vector index. When the core acknowledges the request, the block clears the served flag and drops the global enable, which blocks nesting. A return pulse from the core restores the global enable.

Software reaches the status, mask, sense and flag registers through a single-cycle write strobe and a combinational read port.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, `irq_req_o` is 0, `irq_vec_o` is 0, and every register address reads 0.
- R2: Register map (3-bit address):
  - 0 is status, with the global enable in bit 7.
  - 1 is mask, with the source enables in bits 2:0.
  - 2 holds source 0's sense code in bits 1:0 and source 1's sense code in bits 3:2.
  - 3 holds source 2's edge select in bit 0.
  - 4 is the pending flags, bits 2:0.
  - Register bits not listed here read as 0.
- R3: While the global enable is 0, `irq_req_o` stays 0 even when an enabled source is pending.
- R4: A source whose mask bit is 0 raises no request, but its flag is still set by an edge.
- R5: Two-bit sense codes are 00 low level, 01 any change, 10 falling edge and 11 rising edge. Source 2's bit selects a falling edge when 0 and a rising edge when 1. Only the selected edge sets the flag.
- R6: A pin change driven between clock edges k and k+1 is visible in the flag register after edge k+3, and not yet after edge k+2.
- R7: In level mode, a source requests while its pin has been low for two edges. It sets no flag, and its request drops two edges after the pin returns high.
- R8: Among requesting sources, 0 beats 1 and 1 beats 2. `irq_vec_o` gives 1, 2 or 3 for sources 0, 1 and 2, and gives 0 when there is no request.
- R9: `irq_ack_i` during a request clears the served source's flag and clears the global enable. `irq_req_o` is 0 in the following cycle.
- R10: An `irq_ret_i` pulse sets the global enable.
- R11: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R12: `irq_ack_i` while `irq_req_o` is 0 changes neither the flags nor the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 3 | External request pins, idle high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 2 | Vector index of the request |
| irq_ack_i | input | 1 | Core accepts the request |
| irq_ret_i | input | 1 | Core returns from the handler |

## Verification
A stuck or mis-set synchronizer or compare stage would show as a flag that rises one edge early or late, or on the wrong edge direction. It would appear in the flag register within three clock edges of the pin change. A wrong global enable or acknowledge path would show in the cycle right after an acknowledge or return pulse, as a request that persists or never comes back. A faulty priority chain would show at once on `irq_vec_o` when several flags are pending together.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NSRC    = 3;
  localparam int DW      = 8;
  localparam int AW      = 3;
  localparam int VW      = $clog2(NSRC + 1);
  localparam int GIE_BIT = 7;

  localparam logic [AW-1:0] A_STAT  = 3'd0;
  localparam logic [AW-1:0] A_MASK  = 3'd1;
  localparam logic [AW-1:0] A_SNS01 = 3'd2;
  localparam logic [AW-1:0] A_SNS2  = 3'd3;
  localparam logic [AW-1:0] A_FLAG  = 3'd4;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/xirq_rstsync.sv
module xirq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else begin
      st1_q <= 1'b1;
      st2_q <= st1_q;
    end
  end

  assign rst_sn = st2_q;
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_sn,
  input  logic   pin_i,
  input  sense_e mode_i,
  output logic   hit_o,
  output logic   low_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;
  assign low_o = ~s2_q;

  always_comb begin
    unique case (mode_i)
      SNS_ANY:  hit_o = rise | fall;
      SNS_FALL: hit_o = fall;
      SNS_RISE: hit_o = rise;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xirq_prio.sv
module xirq_prio #(
  parameter int N  = 3,
  parameter int VW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VW'(i + 1);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] ext_pin_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_req_o,
  output logic [VW-1:0] irq_vec_o,
  input  logic          irq_ack_i,
  input  logic          irq_ret_i
);
  logic            rst_sn;
  logic            gie_q, gie_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] flag_q, flag_d;
  logic [3:0]      sns01_q, sns01_d;
  logic            sns2_q, sns2_d;
  sense_e          mode [NSRC];
  logic [NSRC-1:0] hit, low, is_edge, pend, active, served;
  logic            any;
  logic [VW-1:0]   vec;
  logic            take;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata_i[6:4];

  xirq_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  always_comb begin
    mode[0] = sense_e'(sns01_q[1:0]);
    mode[1] = sense_e'(sns01_q[3:2]);
    mode[2] = sns2_q ? SNS_RISE : SNS_FALL;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    xirq_detect #(.IDLE(1'b1)) u_det (
      .clk   (clk),
      .rst_sn(rst_sn),
      .pin_i (ext_pin_i[i]),
      .mode_i(mode[i]),
      .hit_o (hit[i]),
      .low_o (low[i])
    );
    assign is_edge[i] = (mode[i] != SNS_LOW);
    assign pend[i]    = is_edge[i] ? flag_q[i] : low[i];
    assign served[i]  = take && (vec == VW'(i + 1));

    // R7
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      (mode[i] == SNS_LOW && $past(mode[i] == SNS_LOW) && !$past(flag_q[i]))
        |-> !flag_q[i]);
  end

  assign active = pend & mask_q;

  xirq_prio #(.N(NSRC), .VW(VW)) u_prio (.req_i(active), .any_o(any), .vec_o(vec));

  assign irq_req_o = gie_q & any;
  assign irq_vec_o = irq_req_o ? vec : '0;
  assign take      = irq_ack_i & irq_req_o;

  // next-state
  always_comb begin
    mask_d  = mask_q;
    sns01_d = sns01_q;
    sns2_d  = sns2_q;
    flag_d  = flag_q;
    gie_d   = gie_q;
    if (reg_we_i) begin
      unique case (reg_addr_i)
        A_MASK:  mask_d  = reg_wdata_i[NSRC-1:0];
        A_SNS01: sns01_d = reg_wdata_i[3:0];
        A_SNS2:  sns2_d  = reg_wdata_i[0];
        A_FLAG:  flag_d  = flag_q & ~reg_wdata_i[NSRC-1:0];
        default: ;
      endcase
    end
    flag_d = (flag_d & ~served) | (hit & is_edge);
    if (take)
      gie_d = 1'b0;
    else if (irq_ret_i)
      gie_d = 1'b1;
    else if (reg_we_i && reg_addr_i == A_STAT)
      gie_d = reg_wdata_i[GIE_BIT];
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gie_q   <= 1'b0;
      mask_q  <= '0;
      flag_q  <= '0;
      sns01_q <= '0;
      sns2_q  <= 1'b0;
    end else begin
      gie_q   <= gie_d;
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      sns01_q <= sns01_d;
      sns2_q  <= sns2_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STAT:  reg_rdata_o[GIE_BIT]  = gie_q;
      A_MASK:  reg_rdata_o[NSRC-1:0] = mask_q;
      A_SNS01: reg_rdata_o[3:0]      = sns01_q;
      A_SNS2:  reg_rdata_o[0]        = sns2_q;
      A_FLAG:  reg_rdata_o[NSRC-1:0] = flag_q;
      default: ;
    endcase
  end

  // R9
  ack_block_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    take |=> !irq_req_o);

  // R10
  ret_gie_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_ret_i && !take) |=> gie_q);

  // R8
  prio_top_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_req_o && active[0]) |-> irq_vec_o == VW'(1));

  // R12
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_ack_i && !irq_req_o && !irq_ret_i && !reg_we_i) |=> gie_q == $past(gie_q));
endmodule

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pins = 3'b111;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       req;
  logic [1:0] vec;
  logic       ack = 1'b0;
  logic       ret = 1'b0;
  int nchk = 0;
  int nfail = 0;

  always #(CLK_PER/2) clk = ~clk;

  xirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(pins),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .irq_ret_i(ret)
  );

  // {code[1:0], pin before, pin after, expected flag}
  localparam logic [4:0] TV [8] = '{
    5'b01_0_1_1, 5'b01_1_0_1, 5'b10_0_1_0, 5'b10_1_0_1,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b00_0_1_0, 5'b00_1_0_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_ret;
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    cyc(2); rst_n = 1'b1; cyc(4);

    // R1 reset state
    chk("R1 req", req, 0);
    chk("R1 vec", vec, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 0);
    end

    // R2 register map and unused bits
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R2 mask", d, 8'h07);
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R2 sense01", d, 8'h0F);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R2 sense2", d, 8'h01);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R2 stat", d, 8'h80);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'h07);

    // R5 sense table on source 0
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pins[0] = TV[i][2];
      wr(3'd2, {6'b0, TV[i][4:3]});
      cyc(4);
      wr(3'd4, 8'h01);
      @(negedge clk); pins[0] = TV[i][1];
      cyc(4);
      rd(3'd4, d); chk("R5 table", d[0], TV[i][0]);
    end
    @(negedge clk); pins = 3'b111; cyc(4); wr(3'd4, 8'h07);

    // R5 source 2 edge select
    wr(3'd3, 8'h00); @(negedge clk); pins[2] = 1'b0; cyc(4);
    rd(3'd4, d); chk("R5 src2 fall", d[2], 1);
    wr(3'd4, 8'h04); wr(3'd3, 8'h01); @(negedge clk); pins[2] = 1'b1; cyc(4);
    rd(3'd4, d); chk("R5 src2 rise", d[2], 1);
    wr(3'd4, 8'h04); @(negedge clk); pins[2] = 1'b0; cyc(4);
    rd(3'd4, d); chk("R5 src2 fall ignored", d[2], 0);
    @(negedge clk); pins[2] = 1'b1; cyc(4); wr(3'd4, 8'h07);

    // R6 latency
    wr(3'd2, 8'h03); @(negedge clk); pins[0] = 1'b0; cyc(4); wr(3'd4, 8'h07);
    @(negedge clk); pins[0] = 1'b1;
    cyc(2); rd(3'd4, d); chk("R6 early", d[0], 0);
    cyc(1); rd(3'd4, d); chk("R6 on time", d[0], 1);

    // R11 write-one-to-clear
    wr(3'd4, 8'h00); rd(3'd4, d); chk("R11 zero keeps", d[0], 1);
    wr(3'd4, 8'h01); rd(3'd4, d); chk("R11 one clears", d[0], 0);

    // R3 / R4 / R8 / R9 / R10 / R12
    wr(3'd2, 8'h0A); wr(3'd3, 8'h00); wr(3'd4, 8'h07);
    @(negedge clk); pins[1] = 1'b0; cyc(4);
    wr(3'd1, 8'h02);
    chk("R3 gie off", req, 0);
    rd(3'd4, d); chk("R3 flag", d, 8'h02);
    wr(3'd1, 8'h00); wr(3'd0, 8'h80);
    chk("R4 masked", req, 0);
    rd(3'd4, d); chk("R4 flag kept", d, 8'h02);
    wr(3'd1, 8'h07);
    chk("R8 req", req, 1); chk("R8 vec src1", vec, 2);
    @(negedge clk); pins[0] = 1'b0; pins[2] = 1'b0; cyc(4);
    chk("R8 vec src0 first", vec, 1);
    pulse_ack();
    chk("R9 req drops", req, 0);
    rd(3'd4, d); chk("R9 flag0 cleared", d, 8'h06);
    rd(3'd0, d); chk("R9 gie cleared", d, 8'h00);
    pulse_ack();
    rd(3'd4, d); chk("R12 flags kept", d, 8'h06);
    rd(3'd0, d); chk("R12 gie kept", d, 8'h00);
    pulse_ret();
    rd(3'd0, d); chk("R10 gie set", d, 8'h80);
    chk("R10 vec src1", vec, 2);
    pulse_ack(); pulse_ret();
    chk("R8 vec src2", vec, 3);
    pulse_ack(); pulse_ret();
    chk("R8 none req", req, 0); chk("R8 none vec", vec, 0);
    rd(3'd4, d); chk("R9 all served", d, 8'h00);

    // R7 level mode
    @(negedge clk); pins = 3'b111; cyc(4);
    wr(3'd2, 8'h00); wr(3'd1, 8'h01); wr(3'd4, 8'h07);
    @(negedge clk); pins[0] = 1'b0;
    cyc(1); chk("R7 not yet", req, 0);
    cyc(1); chk("R7 level req", req, 1); chk("R7 vec", vec, 1);
    rd(3'd4, d); chk("R7 no flag", d, 8'h00);
    @(negedge clk); pins[0] = 1'b1;
    cyc(1); chk("R7 still", req, 1);
    cyc(1); chk("R7 release", req, 0);

    summary();
  end
endmodule